// File: doc/BRIEF.md
# Command Packet Packer for a Display Serial Link Host

This block is the command-mode front end of a host for a serial display link. Software fills a payload queue with 32-bit words and then writes a 32-bit header word into a header queue. The block turns each header into a short packet (four header bytes) or a long packet (four header bytes followed by the payload bytes) and sends it out as a byte stream with start and end markers and a valid/ready handshake. A long packet starts only when its header has reached the front of the header queue and enough payload words are queued to cover its byte count.

On the return path, words of a read response are pushed into a receive queue by the link side, and a completion pulse raises a read-done flag. Software polls a status word, then pops the response words through the same register address it uses to push transmit payload. Software unpacks each word lowest byte first until it has the number of bytes it asked for or the receive queue is empty. Lane serialisation and the error-check fields of the packets are handled elsewhere: the fourth header byte is sent as zero and long packets carry no trailing checksum.

Register addresses (2-bit word address): 0 = header queue (write), 1 = transmit payload queue (write) / receive queue (read), 2 = status (read).

Top module: `cmd_pkt_engine`

## Requirements
- R1: Each packet starts with four header bytes in this order: header bits 7:0 (data type in 5:0, virtual channel in 7:6), bits 15:8, bits 23:16, then a zero byte; the start marker is high on the first of them only.
- R2: A header whose data type has low nibble 0x9, 0xC, 0xD or 0xE is a long packet with byte count equal to header bits 23:8; any other data type is a short packet of exactly four bytes, with bits 15:8 and 23:16 carried as the two parameters.
- R3: The payload bytes of a long packet follow the header, four per queued word with bits 7:0 first, exactly byte-count bytes; the unused bytes of a final partial word are discarded.
- R4: A long packet is not started (valid stays low) until at least ceil(byte count / 4) payload words are queued; it starts once the missing words arrive.
- R5: The end marker is high on the last byte of a packet only; a long packet with byte count 0 ends on its fourth header byte.
- R6: The status word (address 2) has receive-queue-empty at bit 1, payload-queue-empty at bit 3, header-queue-empty at bit 5, read-done at bit 7; after reset it reads 0x2A.
- R7: Both transmit queues hold 16 words; a write to a full queue is dropped and sets a sticky flag (bit 8 header, bit 9 payload) that a status read clears.
- R8: Words pushed on the receive input are returned in order by reads of address 1; a read of an empty receive queue returns 0 and changes nothing.
- R9: A completion pulse sets read-done; a write to the header address clears it.
- R10: While valid is high and ready is low, the output byte and both markers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (pops receive queue / clears flags) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, valid in the cycle of the address |
| rx_word_valid | input | 1 | Pushes one received response word |
| rx_word | input | 32 | Received response word |
| rx_done | input | 1 | Pulse: read response complete |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |

## Verification
The hardest situation to reach is a long packet whose header is queued before all of its payload, since well-behaved software never does that; the bench writes one payload word, then the header, holds the sink ready and watches valid stay low before supplying the second word. Queue overflow is the other awkward case: the header queue only fills when the sink stalls, so the bench forces ready low while writing eighteen headers back to back, one of which the serializer has already taken. The payload queue is overfilled with no header pending, and the sixteen surviving words are then drained as one 64-byte packet to confirm that nothing was corrupted.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  localparam logic [1:0] REG_HDR  = 2'd0;
  localparam logic [1:0] REG_PLD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  localparam int ST_RX_EMPTY  = 1;
  localparam int ST_PLD_EMPTY = 3;
  localparam int ST_HDR_EMPTY = 5;
  localparam int ST_RD_DONE   = 7;
  localparam int ST_HDR_OVF   = 8;
  localparam int ST_PLD_OVF   = 9;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_HDR = 2'd1, S_BODY = 2'd2} ser_state_e;

  // Data types carrying a byte count and a body.
  function automatic logic is_long_dt(input logic [5:0] dt);
    case (dt[3:0])
      4'h9, 4'hC, 4'hD, 4'hE: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  // Number of 32-bit words needed to hold n bytes.
  function automatic logic [14:0] words_for_bytes(input logic [15:0] n);
    logic [16:0] t;
    t = {1'b0, n} + 17'd3;
    return t[16:2];
  endfunction

  // Header byte by index; the fourth byte is reserved and sent as zero.
  function automatic logic [7:0] hdr_byte(input logic [23:0] h, input logic [1:0] idx);
    case (idx)
      2'd0:    return h[7:0];
      2'd1:    return h[15:8];
      2'd2:    return h[23:16];
      default: return 8'h00;
    endcase
  endfunction

  // Byte lane of a payload word, lane 0 in bits 7:0.
  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

endpackage

// File: rtl/cpp_fifo.sv
module cpp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R7: a dropped write leaves the queue full
  a_r7_drop_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

  // R8: popping an empty queue with no push leaves it empty
  a_r8_pop_empty_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/cpp_tx_serializer.sv
module cpp_tx_serializer
  import cpp_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_empty,
  input  logic [31:0]   hdr_word,
  output logic          hdr_pop,
  input  logic [CW-1:0] pld_count,
  input  logic          pld_empty,
  input  logic [31:0]   pld_word,
  output logic          pld_pop,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sop,
  output logic          tx_eop
);

  ser_state_e  st;
  logic [23:0] hdr_q;
  logic        long_q;
  logic [1:0]  idx, lane;
  logic [15:0] remain;

  // Named internal events for assertions
  logic        launch, fire, has_body, body_last, hdr_last;
  logic [14:0] need_words;
  logic        unused_sink;

  assign unused_sink = ^hdr_word[31:24];

  assign need_words = words_for_bytes(hdr_word[23:8]);
  assign launch     = (st == S_IDLE) && !hdr_empty &&
                      (!is_long_dt(hdr_word[5:0]) || (32'(need_words) <= 32'(pld_count)));
  assign has_body   = long_q && (hdr_q[23:8] != 16'd0);
  assign hdr_last   = (st == S_HDR) && (idx == 2'd3);
  assign body_last  = (st == S_BODY) && (remain == 16'd1);

  assign tx_valid = (st != S_IDLE);
  assign fire     = tx_valid && tx_ready;
  assign tx_data  = (st == S_HDR) ? hdr_byte(hdr_q, idx) : word_byte(pld_word, lane);
  assign tx_sop   = (st == S_HDR) && (idx == 2'd0);
  assign tx_eop   = (hdr_last && !has_body) || body_last;
  assign hdr_pop  = launch;
  assign pld_pop  = fire && (st == S_BODY) && ((lane == 2'd3) || (remain == 16'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hdr_q  <= '0;
      long_q <= 1'b0;
      idx    <= '0;
      lane   <= '0;
      remain <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          hdr_q  <= hdr_word[23:0];
          long_q <= is_long_dt(hdr_word[5:0]);
          idx    <= 2'd0;
          st     <= S_HDR;
        end
        S_HDR: if (fire) begin
          if (idx == 2'd3) begin
            if (has_body) begin
              st     <= S_BODY;
              remain <= hdr_q[23:8];
              lane   <= 2'd0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_BODY: if (fire) begin
          remain <= remain - 16'd1;
          lane   <= lane + 2'd1;
          if (remain == 16'd1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: stalled byte and markers hold
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eop) && $stable(tx_sop)));

  // R4: the body never runs ahead of queued payload
  a_r4_body_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BODY) |-> !pld_empty);

  // R1: start marker only on a valid byte
  a_r1_sop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> tx_valid);

  // R5: after an accepted last byte the next byte, if any, starts a packet
  a_r5_eop_then_sop: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && tx_eop) |=> (!tx_valid || tx_sop));

endmodule

// File: rtl/cpp_regif.sv
module cpp_regif
  import cpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        hdr_push,
  output logic        pld_push,
  output logic        rx_pop,
  input  logic        hdr_empty,
  input  logic        pld_empty,
  input  logic        rx_empty,
  input  logic [31:0] rx_head,
  input  logic        hdr_drop,
  input  logic        pld_drop,
  input  logic        rx_done
);

  logic        hdr_ovf, pld_ovf, rd_done;
  logic        stat_rd;
  logic [31:0] status;

  assign hdr_push = wr_en && (wr_addr == REG_HDR);
  assign pld_push = wr_en && (wr_addr == REG_PLD);
  assign rx_pop   = rd_en && (rd_addr == REG_PLD) && !rx_empty;
  assign stat_rd  = rd_en && (rd_addr == REG_STAT);

  always_comb begin
    status               = '0;
    status[ST_RX_EMPTY]  = rx_empty;
    status[ST_PLD_EMPTY] = pld_empty;
    status[ST_HDR_EMPTY] = hdr_empty;
    status[ST_RD_DONE]   = rd_done;
    status[ST_HDR_OVF]   = hdr_ovf;
    status[ST_PLD_OVF]   = pld_ovf;
  end

  always_comb begin
    case (rd_addr)
      REG_STAT: rd_data = status;
      REG_PLD:  rd_data = rx_empty ? 32'd0 : rx_head;
      default:  rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_ovf <= 1'b0;
      pld_ovf <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      if (hdr_drop)     hdr_ovf <= 1'b1;
      else if (stat_rd) hdr_ovf <= 1'b0;
      if (pld_drop)     pld_ovf <= 1'b1;
      else if (stat_rd) pld_ovf <= 1'b0;
      if (rx_done)       rd_done <= 1'b1;
      else if (hdr_push) rd_done <= 1'b0;
    end
  end

  // R9: completion sets the flag, a header write clears it
  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rd_done);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_push && !rx_done) |=> !rd_done);

  // R7: overflow flags stay until a status read
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ovf && !stat_rd) |=> hdr_ovf);

endmodule

// File: rtl/cmd_pkt_engine.sv
module cmd_pkt_engine
  import cpp_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        rx_word_valid,
  input  logic [31:0] rx_word,
  input  logic        rx_done,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop
);

  localparam int TXC = $clog2(TX_DEPTH + 1);
  localparam int RXC = $clog2(RX_DEPTH + 1);

  logic           hdr_push, hdr_pop, hdr_empty, hdr_full, hdr_drop;
  logic [31:0]    hdr_head;
  logic [TXC-1:0] hdr_count;
  logic           pld_push, pld_pop, pld_empty, pld_full, pld_drop;
  logic [31:0]    pld_head;
  logic [TXC-1:0] pld_count;
  logic           rx_pop, rx_empty, rx_full, rx_drop;
  logic [31:0]    rx_head;
  logic [RXC-1:0] rx_count;
  logic           unused_sink;

  assign unused_sink = ^{hdr_full, hdr_count, pld_full, rx_full, rx_drop, rx_count};

  cpp_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_hdr_q (
    .clk, .rst_n, .push(hdr_push), .wdata(wr_data), .pop(hdr_pop), .rdata(hdr_head),
    .empty(hdr_empty), .full(hdr_full), .count(hdr_count), .drop(hdr_drop));

  cpp_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_pld_q (
    .clk, .rst_n, .push(pld_push), .wdata(wr_data), .pop(pld_pop), .rdata(pld_head),
    .empty(pld_empty), .full(pld_full), .count(pld_count), .drop(pld_drop));

  cpp_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk, .rst_n, .push(rx_word_valid), .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_count), .drop(rx_drop));

  cpp_regif u_regif (
    .clk, .rst_n, .wr_en, .wr_addr, .rd_en, .rd_addr, .rd_data,
    .hdr_push, .pld_push, .rx_pop, .hdr_empty, .pld_empty, .rx_empty, .rx_head,
    .hdr_drop, .pld_drop, .rx_done);

  cpp_tx_serializer #(.CW(TXC)) u_ser (
    .clk, .rst_n, .hdr_empty, .hdr_word(hdr_head), .hdr_pop,
    .pld_count, .pld_empty, .pld_word(pld_head), .pld_pop,
    .tx_valid, .tx_ready, .tx_data, .tx_sop, .tx_eop);

endmodule

// File: tb/test_cmd_pkt_engine.sv
module test_cmd_pkt_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rx_word_valid = 1'b0;
  logic [31:0] rx_word = '0;
  logic        rx_done = 1'b0;
  logic        tx_valid, tx_ready, tx_sop, tx_eop;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  int ready_mode = 2;          // 0 random, 1 stall, 2 always ready
  logic [7:0] lfsr = 8'h5A;
  logic [9:0] exp_q[$];        // {sop, eop, data}
  int  pos = 0;
  logic held = 1'b0;
  logic [7:0] held_data;
  logic held_eop;
  bit finished = 0;

  always #10 clk = ~clk;       // 50 MHz

  cmd_pkt_engine i_cmd_pkt_engine (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_data,
    .rx_word_valid, .rx_word, .rx_done, .tx_valid, .tx_ready, .tx_data, .tx_sop, .tx_eop);

  function automatic bit tb_long(input logic [5:0] dt);
    return (dt[3:0] == 4'h9) || (dt[3:0] == 4'hC) || (dt[3:0] == 4'hD) || (dt[3:0] == 4'hE);
  endfunction

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7 + 1);
  endfunction

  function automatic logic [31:0] pword(input logic [7:0] seed, input int w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = pbyte(seed, 4*w + k);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #2 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // Scoreboard driver: expected bytes of one packet
  task automatic push_expected(input logic [5:0] dt, input logic [1:0] vc, input int len,
                               input logic [7:0] seed);
    bit lg = tb_long(dt);
    logic [7:0] b1, b2;
    int nbytes;
    b1 = lg ? len[7:0]  : ((len > 0) ? pbyte(seed, 0) : 8'h00);
    b2 = lg ? len[15:8] : ((len > 1) ? pbyte(seed, 1) : 8'h00);
    nbytes = lg ? 4 + len : 4;
    exp_q.push_back({1'b1, nbytes == 1, vc, dt});
    exp_q.push_back({1'b0, 1'b0, b1});
    exp_q.push_back({1'b0, 1'b0, b2});
    exp_q.push_back({1'b0, nbytes == 4, 8'h00});
    if (lg)
      for (int i = 0; i < len; i++)
        exp_q.push_back({1'b0, i == len - 1, pbyte(seed, i)});
  endtask

  task automatic send_pkt(input logic [5:0] dt, input logic [1:0] vc, input int len,
                          input logic [7:0] seed);
    bit lg = tb_long(dt);
    logic [31:0] h;
    push_expected(dt, vc, len, seed);
    if (lg) begin
      for (int w = 0; w < (len + 3) / 4; w++) reg_write(2'd1, pword(seed, w));
      h = {8'h00, len[15:0], vc, dt};
    end else begin
      h = {8'h00, (len > 1) ? pbyte(seed, 1) : 8'h00, (len > 0) ? pbyte(seed, 0) : 8'h00, vc, dt};
    end
    reg_write(2'd0, h);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard monitor
  initial begin
    logic [9:0] e;
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
        0:       tx_ready = lfsr[0] | lfsr[3];
        1:       tx_ready = 1'b0;
        default: tx_ready = 1'b1;
      endcase
      #1;
      if (rst_n) begin
        if (held) begin
          checks++;
          if (!tx_valid || tx_data !== held_data || tx_eop !== held_eop) begin
            errors++;
            $display("FAIL R10 actual=%b/%h expected=1/%h", tx_valid, tx_data, held_data);
          end
        end
        held = tx_valid && !tx_ready;
        held_data = tx_data;
        held_eop = tx_eop;
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4 unexpected byte actual=%h expected=none", tx_data);
          end else begin
            e = exp_q.pop_front();
            check((pos < 4) ? "R1 header byte" : "R3 payload byte", tx_data, e[7:0]);
            check("R2 R5 end marker", tx_eop, e[8]);
            check("R1 start marker", tx_sop, e[9]);
            pos = tx_eop ? 0 : pos + 1;
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] rxw[3];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    reg_read(2'd2, d);
    check("R6 reset status", d, 32'h2A);
    check("R6 idle after reset", tx_valid, 1'b0);

    // Short packets (R1, R2)
    ready_mode = 0;
    send_pkt(6'h05, 2'd0, 0, 8'h10); drain();
    send_pkt(6'h15, 2'd2, 2, 8'h20); drain();
    send_pkt(6'h03, 2'd1, 1, 8'h30); drain();
    // Long packets (R3, R5): partial word, exact word, zero length
    send_pkt(6'h39, 2'd1, 7, 8'h40); drain();
    send_pkt(6'h29, 2'd3, 4, 8'h50); drain();
    send_pkt(6'h29, 2'd2, 0, 8'h60); drain();
    send_pkt(6'h2C, 2'd0, 13, 8'h70); drain();

    // R4: header before all payload
    ready_mode = 2;
    push_expected(6'h39, 2'd0, 8, 8'h80);
    reg_write(2'd1, pword(8'h80, 0));
    reg_write(2'd0, {8'h00, 16'd8, 2'd0, 6'h39});
    repeat (8) begin
      @(negedge clk); #2;
      check("R4 waits for payload", tx_valid, 1'b0);
    end
    reg_write(2'd1, pword(8'h80, 1));
    drain();

    // R7: header queue overflow under a stalled sink
    ready_mode = 1;
    for (int k = 0; k < 18; k++) begin
      if (k < 17) push_expected(6'h05, 2'(k), 2, 8'(k));
      reg_write(2'd0, {8'h00, pbyte(8'(k), 1), pbyte(8'(k), 0), 2'(k), 6'h05});
    end
    reg_read(2'd2, d);
    check("R7 header overflow flag", d, 32'h10A);
    reg_read(2'd2, d);
    check("R7 flag cleared by status read", d, 32'h00A);
    ready_mode = 0;
    drain();

    // R7: payload queue overflow, then 64-byte packet from the kept words
    ready_mode = 2;
    for (int w = 0; w < 16; w++) reg_write(2'd1, pword(8'h90, w));
    reg_write(2'd1, 32'hDEADBEEF);
    reg_read(2'd2, d);
    check("R7 payload overflow flag", d, 32'h222);
    reg_read(2'd2, d);
    check("R7 payload flag cleared", d, 32'h022);
    push_expected(6'h29, 2'd3, 64, 8'h90);
    reg_write(2'd0, {8'h00, 16'd64, 2'd3, 6'h29});
    drain();

    // R8, R9: receive path
    for (int k = 0; k < 3; k++) begin
      rxw[k] = pword(8'hC0, k);
      @(negedge clk); rx_word_valid = 1'b1; rx_word = rxw[k];
      @(posedge clk); #1 rx_word_valid = 1'b0;
    end
    @(negedge clk); rx_done = 1'b1;
    @(posedge clk); #1 rx_done = 1'b0;
    reg_read(2'd2, d);
    check("R9 read done set", d, 32'hA8);
    begin
      int cnt = 0;
      for (int k = 0; k < 3; k++) begin
        reg_read(2'd1, d);
        check("R8 receive word order", d, rxw[k]);
        for (int b = 0; b < 4; b++)
          if (cnt < 10) begin
            check("R8 unpacked byte", d[8*b +: 8], pbyte(8'hC0, cnt));
            cnt++;
          end
      end
    end
    reg_read(2'd2, d);
    check("R6 receive empty bit", d, 32'hAA);
    reg_read(2'd1, d);
    check("R8 empty read returns zero", d, 32'h0);
    reg_read(2'd2, d);
    check("R8 empty read has no effect", d, 32'hAA);
    send_pkt(6'h05, 2'd1, 1, 8'hD0);
    drain();
    reg_read(2'd2, d);
    check("R9 header write clears done", d, 32'h2A);

    check("R3 final queue empty", exp_q.size(), 0);
    finish_run();
  end

endmodule